// File: doc/BRIEF.md
# Read Capture Deskew Calibration Engine

This engine tunes read capture timing for one byte lane of a double-data-rate memory interface. It runs once during power-up initialisation. Software or the init sequencer pulses `start_i`, and the engine turns on the memory's fixed-pattern mode. It then steps the strobe delay code from 0 up to 63. After each code change it waits a fixed settle time, then issues a set number of reads. Each data bit is compared against a known alternating burst, and the engine records the first and last strobe code at which that bit passed.

After the sweep, the engine intersects the passing windows of all bits and places the strobe delay at the middle of that intersection. It then gives each data bit its own delay code, which slides that bit's window so that the window's centre falls on the chosen strobe code. If a bit never passes, or the windows share no common code, the engine raises an error flag along with done. In that case the strobe code and all bit codes stay at their default mid-scale value. The delay lines, the PHY and the memory are outside this block.

Top module: `rd_deskew_cal`

## Requirements
- R1: After reset, `done_o`, `err_o`, `pat_mode_o` and `rd_req_o` are 0, and the strobe code and all eight bit codes equal the default code 32.
- R2: `pat_mode_o` rises in the cycle after an accepted start and stays high for the whole sweep. Every read request is made with it high, and it is low once `done_o` is set.
- R3: During the sweep the strobe code starts at 0 and increases by exactly one per step up to 63. All 64 codes are visited.
- R4: The first read request of each step appears exactly SETTLE (default 4) cycles after the cycle in which the new strobe code first shows on `dqs_dly_o`.
- R5: Each step issues exactly NMATCH (default 2) reads. A bit passes a step only if it matched in every one of those reads. The expected value of bit j in beat b is (b+j) mod 2, and beat b occupies `rd_data_i[b*8 +: 8]`, with 4 beats.
- R6: Per bit, the lowest and highest passing codes are kept. The chosen strobe code is floor((max of lowest + min of highest)/2).
- R7: Bit j receives code 32 + strobe − floor((low_j + high_j)/2), clamped to the range 0..63.
- R8: If any bit never passes, or the largest low exceeds the smallest high, `err_o` and `done_o` are set together and all codes read 32.
- R9: `done_o` and the result codes hold until the next start. A start pulse during a run is ignored, and a start after done runs a fresh calibration that clears `err_o`.
- R10: `rd_req_o` is a single-cycle pulse. No new request is issued until `rd_vld_i` has returned data for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start calibration pulse |
| done_o | output | 1 | Calibration finished (held) |
| err_o | output | 1 | Calibration failed, valid with done |
| pat_mode_o | output | 1 | Memory fixed-pattern mode enable |
| rd_req_o | output | 1 | Read burst request pulse |
| rd_vld_i | input | 1 | Captured burst valid |
| rd_data_i | input | 32 | Captured burst, 4 beats of 8 bits |
| dqs_dly_o | output | 6 | Strobe delay code |
| dq_dly_o | output | 48 | Per-bit delay codes, bit j at [j*6 +: 6] |

## Verification
The assertions assume that the capture side answers each request with exactly one `rd_vld_i` pulse, at least one cycle later, and never sends unrequested data. They also assume that `start_i` is only a short pulse. The bench's memory model obeys these rules: it holds a single pending response with a fixed two-cycle latency, and it keeps the returned data constant while the strobe code is fixed. Pass windows are contiguous per bit, with one deliberately flaky read. This makes the expected low and high codes known exactly.

// File: rtl/rdcal_pkg.sv
`timescale 1ns/1ps
package rdcal_pkg;
    localparam int CODE_W   = 6;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] code_t;

    // Passing window seen so far for one data bit
    typedef struct packed {
        logic  seen;
        code_t first;
        code_t last;
    } win_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAIT,
        ST_EVAL,
        ST_CALC,
        ST_DONE
    } cal_state_e;

    // Reference burst: bits alternate across lanes and across beats
    function automatic logic ref_bit(input int beat, input int lane);
        return ((beat + lane) % 2) == 1;
    endfunction

    function automatic code_t half_sum(input code_t a, input code_t b);
        logic [CODE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CODE_W:1];
    endfunction
endpackage

// File: rtl/rdcal_win_track.sv
`timescale 1ns/1ps
module rdcal_win_track
    import rdcal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  logic  pass,
    input  code_t step,
    output win_t  win
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win <= '0;
        end else if (upd && pass) begin
            if (!win.seen) begin
                win.seen  <= 1'b1;
                win.first <= step;
            end
            win.last <= step;
        end
    end

    // R6: the low edge never lies above the high edge
    a_r6_first_le_last: assert property (@(posedge clk) disable iff (rst)
        win.seen |-> (win.first <= win.last));
endmodule

// File: rtl/rdcal_centre.sv
`timescale 1ns/1ps
module rdcal_centre
    import rdcal_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int DEF_CODE = 32
) (
    input  win_t                          win_i [NBITS],
    output code_t                         dqs_sel,
    output logic [NBITS-1:0][CODE_W-1:0]  dq_sel,
    output logic                          fail
);
    code_t lo, hi;
    logic  all_seen;

    always_comb begin
        lo       = '0;
        hi       = code_t'(CODE_MAX);
        all_seen = 1'b1;
        for (int j = 0; j < NBITS; j++) begin
            if (!win_i[j].seen) all_seen = 1'b0;
            if (win_i[j].first > lo) lo = win_i[j].first;
            if (win_i[j].last  < hi) hi = win_i[j].last;
        end
        fail    = !all_seen || (lo > hi);
        dqs_sel = half_sum(lo, hi);
    end

    for (genvar j = 0; j < NBITS; j++) begin : g_lane
        int v;
        always_comb begin
            v = DEF_CODE + int'(dqs_sel) - int'(half_sum(win_i[j].first, win_i[j].last));
            if (v < 0)             dq_sel[j] = '0;
            else if (v > CODE_MAX) dq_sel[j] = code_t'(CODE_MAX);
            else                   dq_sel[j] = code_t'(v);
        end
    end
endmodule

// File: rtl/rd_deskew_cal.sv
`timescale 1ns/1ps
module rd_deskew_cal
    import rdcal_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int BEATS    = 4,
    parameter int SETTLE   = 4,
    parameter int NMATCH   = 2,
    parameter int DEF_CODE = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    output logic                      done_o,
    output logic                      err_o,
    output logic                      pat_mode_o,
    output logic                      rd_req_o,
    input  logic                      rd_vld_i,
    input  logic [NBITS*BEATS-1:0]    rd_data_i,
    output logic [CODE_W-1:0]         dqs_dly_o,
    output logic [NBITS*CODE_W-1:0]   dq_dly_o
);
    localparam int SCNT_W = $clog2(SETTLE + 1);
    localparam int RCNT_W = $clog2(NMATCH + 1);
    localparam int AGE_W  = $clog2(SETTLE + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    cal_state_e                   state;
    logic [SCNT_W-1:0]            scnt;
    logic [RCNT_W-1:0]            rcnt;
    logic [NBITS-1:0]             step_ok, pass_now;
    code_t                        dqs_q;
    logic [NBITS-1:0][CODE_W-1:0] dq_q, dq_sel;
    logic                         done_q, err_q, mode_q, req_q;
    logic                         start_go, fail;
    code_t                        dqs_sel;
    win_t                         win_q [NBITS];

    assign start_go = start_i && (state == ST_IDLE || state == ST_DONE);

    // Bit-wise compare of a captured burst against the reference
    for (genvar j = 0; j < NBITS; j++) begin : g_cmp
        always_comb begin
            pass_now[j] = 1'b1;
            for (int b = 0; b < BEATS; b++)
                if (rd_data_i[b*NBITS + j] != ref_bit(b, j)) pass_now[j] = 1'b0;
        end

        rdcal_win_track u_trk (
            .clk  (clk),
            .rst  (rst),
            .clr  (start_go),
            .upd  (state == ST_EVAL),
            .pass (step_ok[j]),
            .step (dqs_q),
            .win  (win_q[j])
        );
    end

    rdcal_centre #(.NBITS(NBITS), .DEF_CODE(DEF_CODE)) u_centre (
        .win_i   (win_q),
        .dqs_sel (dqs_sel),
        .dq_sel  (dq_sel),
        .fail    (fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            scnt    <= '0;
            rcnt    <= '0;
            step_ok <= '1;
            dqs_q   <= code_t'(DEF_CODE);
            dq_q    <= {NBITS{code_t'(DEF_CODE)}};
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            mode_q  <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (start_go) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
                mode_q <= 1'b1;
                dqs_q  <= '0;
                dq_q   <= {NBITS{code_t'(DEF_CODE)}};
                scnt   <= '0;
                state  <= ST_SETTLE;
            end else begin
                unique case (state)
                    ST_SETTLE: begin
                        if (scnt == SCNT_W'(SETTLE - 1)) begin
                            scnt    <= '0;
                            rcnt    <= '0;
                            step_ok <= '1;
                            req_q   <= 1'b1;
                            state   <= ST_WAIT;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (rd_vld_i) begin
                            step_ok <= step_ok & pass_now;
                            if (rcnt == RCNT_W'(NMATCH - 1)) begin
                                state <= ST_EVAL;
                            end else begin
                                rcnt  <= rcnt + 1'b1;
                                req_q <= 1'b1;
                            end
                        end
                    end
                    ST_EVAL: begin
                        if (dqs_q == code_t'(CODE_MAX)) begin
                            state <= ST_CALC;
                        end else begin
                            dqs_q <= dqs_q + 1'b1;
                            scnt  <= '0;
                            state <= ST_SETTLE;
                        end
                    end
                    ST_CALC: begin
                        if (fail) begin
                            err_q <= 1'b1;
                            dqs_q <= code_t'(DEF_CODE);
                        end else begin
                            dqs_q <= dqs_sel;
                            dq_q  <= dq_sel;
                        end
                        mode_q <= 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done_o     = done_q;
    assign err_o      = err_q;
    assign pat_mode_o = mode_q;
    assign rd_req_o   = req_q;
    assign dqs_dly_o  = dqs_q;
    assign dq_dly_o   = dq_q;

    // Cycles since the strobe code last moved, kept apart from the FSM counter
    code_t            dqs_prev;
    logic [AGE_W-1:0] age_q, age_now;
    logic             pend_q;
    assign age_now = (dqs_q != dqs_prev) ? '0 : age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_prev <= code_t'(DEF_CODE);
            age_q    <= AGE_MAX;
            pend_q   <= 1'b0;
        end else begin
            dqs_prev <= dqs_q;
            age_q    <= (age_now == AGE_MAX) ? AGE_MAX : age_now + 1'b1;
            if (req_q)         pend_q <= 1'b1;
            else if (rd_vld_i) pend_q <= 1'b0;
        end
    end

    a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !$past(rst)) |-> !pend_q);
    a_r2_req_in_mode: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> pat_mode_o);
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (pat_mode_o && $past(pat_mode_o) && dqs_q != $past(dqs_q))
            |-> (dqs_q == code_t'($past(dqs_q) + 1'b1)));
    a_r4_settle_gap: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (age_now >= AGE_W'(SETTLE)));
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(dqs_dly_o) && $stable(dq_dly_o)));
endmodule

// File: tb/tb_rd_deskew_cal.sv
`timescale 1ns/1ps
module tb_rd_deskew_cal;
    localparam int NB = 8, BT = 4, ST = 4, NM = 2, DEF = 32, LAT = 2;

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
    logic done_o, err_o, pat_mode_o, rd_req_o;
    logic rd_vld_i = 1'b0;
    logic [NB*BT-1:0] rd_data_i = '0;
    logic [5:0] dqs_dly_o;
    logic [NB*6-1:0] dq_dly_o;

    rd_deskew_cal #(.NBITS(NB), .BEATS(BT), .SETTLE(ST), .NMATCH(NM), .DEF_CODE(DEF)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o), .err_o(err_o),
        .pat_mode_o(pat_mode_o), .rd_req_o(rd_req_o), .rd_vld_i(rd_vld_i),
        .rd_data_i(rd_data_i), .dqs_dly_o(dqs_dly_o), .dq_dly_o(dq_dly_o));

    always #10 clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_up();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model windows and flaky injection
    int  m_lo [NB];
    int  m_hi [NB];
    bit  fl_en = 0;
    int  fl_lane = 0, fl_code = 0;
    // Effective windows for the expectation
    int  e_lo [NB];
    int  e_hi [NB];

    // Monitor state
    int  pend = 0, rd_idx = 0, last_code = -1, resp_code = 0, resp_idx = 0;
    bit  outst = 0, prev_req = 0;
    int  m_prev, m_gap, m_reqs, m_visits, m_seq_err, m_nm_err, m_set_err, m_prot_err, m_mode_err;

    task automatic mon_clear();
        m_prev = -1; m_gap = 0; m_reqs = 0; m_visits = 0;
        m_seq_err = 0; m_nm_err = 0; m_set_err = 0; m_prot_err = 0; m_mode_err = 0;
    endtask

    always @(negedge clk) begin
        // capture-side model: one pending response, fixed latency
        rd_vld_i = 1'b0;
        if (pend == 1) begin
            rd_vld_i = 1'b1;
            outst = 0;
            for (int b = 0; b < BT; b++)
                for (int j = 0; j < NB; j++) begin
                    bit good, ok;
                    good = ((b + j) % 2) == 1;
                    ok = pat_mode_o && resp_code >= m_lo[j] && resp_code <= m_hi[j];
                    if (fl_en && j == fl_lane && resp_code == fl_code && resp_idx == 1) ok = 0;
                    rd_data_i[b*NB + j] = ok ? good : !good;
                end
        end
        if (pend > 0) pend--;
        if (rd_req_o) begin
            if (int'(dqs_dly_o) != last_code) rd_idx = 0; else rd_idx++;
            last_code = int'(dqs_dly_o);
            resp_code = int'(dqs_dly_o);
            resp_idx = rd_idx;
            if (prev_req || outst) m_prot_err++;
            if (!pat_mode_o) m_mode_err++;
            outst = 1;
            pend = LAT;
        end
        prev_req = rd_req_o;
        // sweep monitor
        if (pat_mode_o) begin
            if (int'(dqs_dly_o) != m_prev) begin
                if (m_prev >= 0 && m_reqs != NM) m_nm_err++;
                if (int'(dqs_dly_o) != m_prev + 1) m_seq_err++;
                m_prev = int'(dqs_dly_o); m_gap = 0; m_reqs = 0; m_visits++;
            end else m_gap++;
            if (rd_req_o) begin
                if (m_reqs == 0 && m_gap != ST) m_set_err++;
                m_reqs++;
            end
        end
    end

    function automatic int dq_of(input int j);
        return int'(dq_dly_o[j*6 +: 6]);
    endfunction

    task automatic set_all(input int lo, input int hi);
        for (int j = 0; j < NB; j++) begin m_lo[j] = lo; m_hi[j] = hi; end
        fl_en = 0;
    endtask

    task automatic copy_eff();
        for (int j = 0; j < NB; j++) begin e_lo[j] = m_lo[j]; e_hi[j] = m_hi[j]; end
    endtask

    // Start, optional ignored start mid-run, then wait for done and check
    task automatic run_and_check(input string tag, input int extra_start_at);
        int lo, hi, dqs, cen, v, w;
        bit fail;
        mon_clear();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(pat_mode_o == 1'b1, {tag, " R2 mode on"}, pat_mode_o, 1);
        chk(done_o == 1'b0, {tag, " R9 done cleared"}, done_o, 0);
        w = 0;
        while (!done_o && w < 20000) begin
            @(negedge clk); w++;
            if (w == extra_start_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, {tag, " R9 done reached"}, done_o, 1);
        lo = 0; hi = 63; fail = 0;
        for (int j = 0; j < NB; j++) begin
            if (e_lo[j] > e_hi[j] || e_lo[j] > 63) fail = 1;
            if (e_lo[j] > lo) lo = e_lo[j];
            if (e_hi[j] < hi) hi = e_hi[j];
        end
        if (lo > hi) fail = 1;
        dqs = (lo + hi) / 2;
        chk(err_o == fail, {tag, " R8 error flag"}, err_o, fail);
        chk(pat_mode_o == 1'b0, {tag, " R2 mode off at done"}, pat_mode_o, 0);
        chk(m_seq_err == 0 && m_visits == 64 && m_prev == 63, {tag, " R3 sweep order"}, m_visits, 64);
        chk(m_set_err == 0, {tag, " R4 settle gap"}, m_set_err, 0);
        chk(m_nm_err == 0 && m_reqs == NM, {tag, " R5 reads per step"}, m_nm_err, 0);
        chk(m_prot_err == 0, {tag, " R10 request protocol"}, m_prot_err, 0);
        chk(m_mode_err == 0, {tag, " R2 reads in mode"}, m_mode_err, 0);
        if (fail) begin
            chk(dqs_dly_o == 6'(DEF), {tag, " R8 strobe default"}, dqs_dly_o, DEF);
            for (int j = 0; j < NB; j++)
                chk(dq_of(j) == DEF, {tag, " R8 bit default"}, dq_of(j), DEF);
        end else begin
            chk(int'(dqs_dly_o) == dqs, {tag, " R6 strobe code"}, dqs_dly_o, dqs);
            for (int j = 0; j < NB; j++) begin
                cen = (e_lo[j] + e_hi[j]) / 2;
                v = DEF + dqs - cen;
                if (v > 63) v = 63;
                if (v < 0) v = 0;
                chk(dq_of(j) == v, {tag, " R7 bit code"}, dq_of(j), v);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !err_o && !pat_mode_o && !rd_req_o, "R1 reset flags", {done_o, err_o, pat_mode_o, rd_req_o}, 0);
        chk(dqs_dly_o == 6'(DEF), "R1 reset strobe", dqs_dly_o, DEF);
        for (int j = 0; j < NB; j++) chk(dq_of(j) == DEF, "R1 reset bit", dq_of(j), DEF);
    endtask

    task automatic t_basic();
        for (int j = 0; j < NB; j++) begin m_lo[j] = 8 + 2*j; m_hi[j] = 40 + j; end
        fl_en = 0; copy_eff();
        run_and_check("basic", -1);
    endtask

    task automatic t_clamp();
        set_all(63, 63); m_lo[0] = 0; copy_eff();
        run_and_check("clamp R7", -1);
    endtask

    task automatic t_flaky();
        set_all(5, 50); m_lo[2] = 10; m_hi[2] = 40;
        fl_en = 1; fl_lane = 2; fl_code = 10;
        copy_eff(); e_lo[2] = 11;
        run_and_check("flaky R5", -1);
    endtask

    task automatic t_dead();
        set_all(5, 50); m_lo[5] = 64; m_hi[5] = 0; copy_eff();
        run_and_check("dead bit R8", -1);
    endtask

    task automatic t_disjoint();
        set_all(0, 63); m_lo[0] = 0; m_hi[0] = 20; m_lo[1] = 30; m_hi[1] = 50; copy_eff();
        run_and_check("disjoint R8", -1);
    endtask

    task automatic t_restart_hold();
        int d0;
        for (int j = 0; j < NB; j++) begin m_lo[j] = 20 - j; m_hi[j] = 50 - 2*j; end
        fl_en = 0; copy_eff();
        run_and_check("busy start R9", 300);
        d0 = int'(dqs_dly_o);
        repeat (40) @(negedge clk);
        chk(done_o == 1'b1, "R9 done held", done_o, 1);
        chk(int'(dqs_dly_o) == d0, "R9 code held", dqs_dly_o, d0);
    endtask

    initial begin
        set_all(0, 63);
        t_reset();
        t_basic();
        t_clamp();
        t_flaky();
        t_dead();
        t_disjoint();
        t_restart_hold();
        finish_up();
    end
endmodule